// File: doc/BRIEF.md
# Update-Based Snooping Cache Coherence Controller

This block manages one processor's small direct-mapped write-back cache in a system where several caches share one bus. Each line is one data word. A present line always carries one of four states: sole-clean, sole-dirty, shared-clean or shared-owner. A line that is not present is simply a tag miss; none of the four states means invalid. A write to a line that other caches may hold is not an invalidation. The new word is broadcast on the bus so the other copies stay current, and memory is not written at that point. The shared-owner state marks the one cache that must eventually write a stale line back.

The processor side is a request/acknowledge pair. The controller masters bus reads, word updates and flushes through a request/grant pair. A transaction takes place in the cycle in which request and grant are both high. In that same cycle, the wired-OR shared sense and the fill data come back from the other agents. On the snoop side, the controller watches the other masters' transactions. It raises shared when it holds the addressed line, and it supplies the data when it owns a dirty copy. An optional per-line usage counter drops a line after a set number of snooped updates that arrive with no local access in between.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset no line is present, so the first read of any address issues a bus read and returns the word supplied on the bus.
- R2: A read miss with shared sense low fills to sole-clean, and a following write hit then makes no bus transaction. With shared sense high the fill lands in shared-clean.
- R3: A read hit returns the cached word with no bus transaction, and cpu_ack is high for exactly one cycle per request.
- R4: A write hit to a shared line issues one bus update that carries the address and the new word, and memory is not written. If shared sense is high during the update, the line becomes shared-owner and supplies data to later snooped reads.
- R5: A bus update issued with shared sense low leaves the line sole-dirty, and a second write then makes no bus transaction.
- R6: A snooped read that hits a dirty line (sole-dirty or shared-owner) asserts shared and supplies the cached word. A sole-dirty line becomes shared-owner.
- R7: A snooped read that hits a sole-clean line asserts shared without supplying data, and the line becomes shared-clean. A later local write then issues a bus update.
- R8: A snooped update that hits stores the broadcast word and asserts shared. A shared-owner line gives up ownership and becomes shared-clean, so it no longer supplies data.
- R9: A miss whose victim is dirty issues a flush (victim address and word) first, then the bus read in the very next bus slot. A clean victim is dropped with no flush.
- R10: With the counter enabled, a fill or a local hit reloads the line's counter to CTR_MAX. Each snooped update that hits decrements it, and the line is dropped silently when the counter reaches zero (the line is clean by then). The next local read then misses.
- R11: Snooped transactions to addresses that are not held (empty index or tag mismatch) assert neither shared nor supply and leave the cache contents unchanged.
- R12: The bus command codes are 0 idle, 1 read, 2 update and 3 flush. A pending read holds bus_req, the command and the address stable until bus_gnt. Only one line-store write occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Write word |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read word, valid with cpu_ack |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Grant; the transaction happens when both are high |
| bus_cmd_o | output | 2 | Command of own transaction |
| bus_addr_o | output | AW | Address of own transaction |
| bus_data_o | output | DW | Update or flush word |
| bus_shared_i | input | 1 | Wired-OR shared sense during own transaction |
| bus_rdata_i | input | DW | Fill word during own read |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_data | input | DW | Snooped update word |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache drives the snooped read data |
| snp_data_o | output | DW | Supplied word |

## Verification
A wrong line state is not visible until the next operation that depends on it. A state left clean when it should be dirty shows up as a missing flush or a missing supply on a later snooped read. A state left sole when it should be shared shows up as a write that fails to issue an update. The tests therefore follow every state-changing event with a probe: a snooped read, a local write or a conflicting miss. The probe exposes the state within a few cycles, through the bus traffic or the supplied word. Stale data from a lost update or a missed fill shows at the next local read hit.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;
   typedef enum logic [1:0] {
      LN_EXCL  = 2'd0,
      LN_MOD   = 2'd1,
      LN_SHCLN = 2'd2,
      LN_SHOWN = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_READ   = 2'd1,
      BC_UPDATE = 2'd2,
      BC_FLUSH  = 2'd3
   } bus_cmd_e;

   function automatic logic st_dirty(input line_st_e s);
      return (s == LN_MOD) || (s == LN_SHOWN);
   endfunction

   function automatic logic st_shared(input line_st_e s);
      return (s == LN_SHCLN) || (s == LN_SHOWN);
   endfunction
endpackage

// File: rtl/upd_coh_line_store.sv
module upd_coh_line_store
   import upd_coh_pkg::*;
#(
   parameter int IW = 4,
   parameter int TW = 4,
   parameter int DW = 16,
   localparam int LINES = 1 << IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_a_idx,
   output logic          rd_a_vld,
   output logic [TW-1:0] rd_a_tag,
   output line_st_e      rd_a_st,
   output logic [DW-1:0] rd_a_data,
   input  logic [IW-1:0] rd_b_idx,
   output logic          rd_b_vld,
   output logic [TW-1:0] rd_b_tag,
   output line_st_e      rd_b_st,
   output logic [DW-1:0] rd_b_data,
   input  logic          wr_a_en,
   input  logic [IW-1:0] wr_a_idx,
   input  logic          wr_a_vld,
   input  logic [TW-1:0] wr_a_tag,
   input  line_st_e      wr_a_st,
   input  logic [DW-1:0] wr_a_data,
   input  logic          wr_b_en,
   input  logic [IW-1:0] wr_b_idx,
   input  logic          wr_b_vld,
   input  logic [TW-1:0] wr_b_tag,
   input  line_st_e      wr_b_st,
   input  logic [DW-1:0] wr_b_data
);
   logic [LINES-1:0] vld_q;
   logic [TW-1:0]    tag_q  [LINES];
   line_st_e         st_q   [LINES];
   logic [DW-1:0]    data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (wr_a_en) vld_q[wr_a_idx] <= wr_a_vld;
         if (wr_b_en) vld_q[wr_b_idx] <= wr_b_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_a_en) begin
         tag_q[wr_a_idx]  <= wr_a_tag;
         st_q[wr_a_idx]   <= wr_a_st;
         data_q[wr_a_idx] <= wr_a_data;
      end
      if (wr_b_en) begin
         tag_q[wr_b_idx]  <= wr_b_tag;
         st_q[wr_b_idx]   <= wr_b_st;
         data_q[wr_b_idx] <= wr_b_data;
      end
   end

   assign rd_a_vld  = vld_q[rd_a_idx];
   assign rd_a_tag  = tag_q[rd_a_idx];
   assign rd_a_st   = st_q[rd_a_idx];
   assign rd_a_data = data_q[rd_a_idx];
   assign rd_b_vld  = vld_q[rd_b_idx];
   assign rd_b_tag  = tag_q[rd_b_idx];
   assign rd_b_st   = st_q[rd_b_idx];
   assign rd_b_data = data_q[rd_b_idx];

   // Local and snoop writes never share a cycle: one bus transaction per cycle.
   assert_one_writer_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_a_en && wr_b_en));
endmodule

// File: rtl/upd_coh_use_ctr.sv
module upd_coh_use_ctr #(
   parameter int IW       = 4,
   parameter int CTR_MAX  = 3,
   parameter bit ENABLE   = 1'b1,
   localparam int LINES   = 1 << IW,
   localparam int CW      = $clog2(CTR_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic [IW-1:0] load_idx,
   input  logic          dec_en,
   input  logic [IW-1:0] dec_idx,
   output logic          expire
);
   initial begin
      assert (CTR_MAX >= 1) else $error("CTR_MAX must be at least 1");
   end

   if (ENABLE) begin : g_on
      logic [CW-1:0] cnt_q [LINES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < LINES; i++) cnt_q[i] <= CW'(CTR_MAX);
         end else begin
            if (dec_en)  cnt_q[dec_idx]  <= cnt_q[dec_idx] - CW'(1);
            if (load_en) cnt_q[load_idx] <= CW'(CTR_MAX);
         end
      end

      assign expire = dec_en && (cnt_q[dec_idx] == CW'(1));

      // A present line always holds a nonzero count.
      assert_ctr_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
         dec_en |-> (cnt_q[dec_idx] != '0));
   end else begin : g_off
      logic unused_ctr_in;
      assign unused_ctr_in = ^{load_en, load_idx, dec_en, dec_idx, clk, rst_n};
      assign expire = 1'b0;
   end
endmodule

// File: rtl/upd_coh_snoop.sv
module upd_coh_snoop
   import upd_coh_pkg::*;
#(
   parameter int TW = 4,
   parameter int DW = 16
) (
   input  logic          snp_valid,
   input  bus_cmd_e      snp_cmd,
   input  logic [TW-1:0] snp_tag,
   input  logic [DW-1:0] snp_data,
   input  logic          ln_vld,
   input  logic [TW-1:0] ln_tag,
   input  line_st_e      ln_st,
   input  logic [DW-1:0] ln_data,
   input  logic          expire,
   output logic          shared_o,
   output logic          supply_o,
   output logic [DW-1:0] supply_data,
   output logic          upd_en,
   output logic          upd_vld,
   output line_st_e      upd_st,
   output logic [DW-1:0] upd_data,
   output logic          dec_en
);
   logic hit;
   assign hit = snp_valid && ln_vld && (ln_tag == snp_tag);
   assign supply_data = ln_data;

   always_comb begin
      shared_o = 1'b0;
      supply_o = 1'b0;
      upd_en   = 1'b0;
      upd_vld  = 1'b1;
      upd_st   = ln_st;
      upd_data = ln_data;
      dec_en   = 1'b0;
      unique case (snp_cmd)
         BC_READ: begin
            shared_o = hit;
            supply_o = hit && st_dirty(ln_st);
            upd_en   = hit;
            if (ln_st == LN_MOD)  upd_st = LN_SHOWN;
            if (ln_st == LN_EXCL) upd_st = LN_SHCLN;
         end
         BC_UPDATE: begin
            shared_o = hit;
            upd_en   = hit;
            dec_en   = hit;
            upd_st   = LN_SHCLN;
            upd_data = snp_data;
            upd_vld  = !expire;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int AW      = 8,
   parameter int DW      = 16,
   parameter int IW      = 4,
   parameter bit USE_CTR = 1'b1,
   parameter int CTR_MAX = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic          cpu_ack,
   output logic [DW-1:0] cpu_rdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [1:0]    bus_cmd_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_data_o,
   input  logic          bus_shared_i,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          snp_valid,
   input  logic [1:0]    snp_cmd,
   input  logic [AW-1:0] snp_addr,
   input  logic [DW-1:0] snp_data,
   output logic          snp_shared_o,
   output logic          snp_supply_o,
   output logic [DW-1:0] snp_data_o
);
   localparam int TW = AW - IW;

   initial begin
      assert (IW >= 1 && IW < AW) else $error("IW must lie in 1..AW-1");
      assert (DW >= 1) else $error("DW must be positive");
   end

   typedef enum logic [2:0] {C_IDLE, C_FLUSH, C_FILL, C_UPD, C_DONE} ctl_e;
   ctl_e cs_q, ns;

   logic [IW-1:0] cpu_idx, snp_idx;
   logic [TW-1:0] cpu_tag, snp_tag;
   assign cpu_idx = cpu_addr[IW-1:0];
   assign cpu_tag = cpu_addr[AW-1:IW];
   assign snp_idx = snp_addr[IW-1:0];
   assign snp_tag = snp_addr[AW-1:IW];

   logic a_vld, b_vld, cpu_hit;
   logic [TW-1:0] a_tag, b_tag;
   line_st_e a_st, b_st;
   logic [DW-1:0] a_data, b_data;
   logic wa_en, wa_vld, ld_en, rdata_ld;
   logic [TW-1:0] wa_tag;
   line_st_e wa_st;
   logic [DW-1:0] wa_data;
   logic wb_en, wb_vld, dec_en, expire;
   line_st_e wb_st;
   logic [DW-1:0] wb_data;
   bus_cmd_e bus_cmd;
   logic [DW-1:0] rdata_q;

   assign cpu_hit = a_vld && (a_tag == cpu_tag);

   upd_coh_line_store #(.IW(IW), .TW(TW), .DW(DW)) store_i (
      .clk, .rst_n,
      .rd_a_idx(cpu_idx), .rd_a_vld(a_vld), .rd_a_tag(a_tag), .rd_a_st(a_st), .rd_a_data(a_data),
      .rd_b_idx(snp_idx), .rd_b_vld(b_vld), .rd_b_tag(b_tag), .rd_b_st(b_st), .rd_b_data(b_data),
      .wr_a_en(wa_en), .wr_a_idx(cpu_idx), .wr_a_vld(wa_vld), .wr_a_tag(wa_tag),
      .wr_a_st(wa_st), .wr_a_data(wa_data),
      .wr_b_en(wb_en), .wr_b_idx(snp_idx), .wr_b_vld(wb_vld), .wr_b_tag(b_tag),
      .wr_b_st(wb_st), .wr_b_data(wb_data));

   upd_coh_use_ctr #(.IW(IW), .CTR_MAX(CTR_MAX), .ENABLE(USE_CTR)) ctr_i (
      .clk, .rst_n, .load_en(ld_en), .load_idx(cpu_idx),
      .dec_en, .dec_idx(snp_idx), .expire);

   upd_coh_snoop #(.TW(TW), .DW(DW)) snoop_i (
      .snp_valid, .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_tag, .snp_data,
      .ln_vld(b_vld), .ln_tag(b_tag), .ln_st(b_st), .ln_data(b_data), .expire,
      .shared_o(snp_shared_o), .supply_o(snp_supply_o), .supply_data(snp_data_o),
      .upd_en(wb_en), .upd_vld(wb_vld), .upd_st(wb_st), .upd_data(wb_data), .dec_en);

   always_comb begin
      ns         = cs_q;
      wa_en      = 1'b0;
      wa_vld     = 1'b1;
      wa_tag     = cpu_tag;
      wa_st      = a_st;
      wa_data    = a_data;
      ld_en      = 1'b0;
      rdata_ld   = 1'b0;
      bus_req    = 1'b0;
      bus_cmd    = BC_IDLE;
      bus_addr_o = cpu_addr;
      bus_data_o = cpu_wdata;
      unique case (cs_q)
         C_IDLE: if (cpu_req && !snp_valid) begin
            if (cpu_hit) begin
               ld_en = 1'b1;
               if (!cpu_we) begin
                  rdata_ld = 1'b1;
                  ns = C_DONE;
               end else if (!st_shared(a_st)) begin
                  wa_en   = 1'b1;
                  wa_st   = LN_MOD;
                  wa_data = cpu_wdata;
                  ns = C_DONE;
               end else begin
                  ns = C_UPD;
               end
            end else begin
               ns = (a_vld && st_dirty(a_st)) ? C_FLUSH : C_FILL;
            end
         end
         C_FLUSH: begin
            if (a_vld && st_dirty(a_st) && !cpu_hit) begin
               bus_req    = 1'b1;
               bus_cmd    = BC_FLUSH;
               bus_addr_o = {a_tag, cpu_idx};
               bus_data_o = a_data;
               if (bus_gnt) begin
                  wa_en  = 1'b1;
                  wa_vld = 1'b0;
                  wa_tag = a_tag;
                  ns = C_FILL;
               end
            end else begin
               ns = C_IDLE;
            end
         end
         C_FILL: begin
            bus_req = 1'b1;
            bus_cmd = BC_READ;
            if (bus_gnt) begin
               wa_en   = 1'b1;
               wa_st   = bus_shared_i ? LN_SHCLN : LN_EXCL;
               wa_data = bus_rdata_i;
               ld_en   = 1'b1;
               ns = C_IDLE;
            end
         end
         C_UPD: begin
            if (cpu_hit && st_shared(a_st)) begin
               bus_req = 1'b1;
               bus_cmd = BC_UPDATE;
               if (bus_gnt) begin
                  wa_en   = 1'b1;
                  wa_st   = bus_shared_i ? LN_SHOWN : LN_MOD;
                  wa_data = cpu_wdata;
                  ns = C_DONE;
               end
            end else begin
               ns = C_IDLE;
            end
         end
         C_DONE: ns = C_IDLE;
         default: ns = C_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= C_IDLE;
         rdata_q <= '0;
      end else begin
         cs_q <= ns;
         if (rdata_ld) rdata_q <= a_data;
      end
   end

   assign bus_cmd_o = bus_cmd;
   assign cpu_ack   = (cs_q == C_DONE);
   assign cpu_rdata = rdata_q;

   assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_ack);
   assert_upd_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd_o == 2'd2) |=> cpu_ack);
   assert_supply_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply_o |-> snp_shared_o);
   assert_fill_after_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd_o == 2'd3) |=> (bus_req && bus_cmd_o == 2'd1));
   assert_read_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && bus_cmd_o == 2'd1) |=>
         (bus_req && bus_cmd_o == 2'd1 && $stable(bus_addr_o)));
endmodule

// File: tb/upd_coh_ctrl_tb.sv
module upd_coh_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        cpu_req = 0, cpu_we = 0;
   logic [7:0]  cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [15:0] cpu_rdata;
   logic        bus_req, bus_gnt, bus_shared_i;
   logic [1:0]  bus_cmd_o;
   logic [7:0]  bus_addr_o;
   logic [15:0] bus_data_o, bus_rdata_i;
   logic        snp_valid = 0;
   logic [1:0]  snp_cmd = '0;
   logic [7:0]  snp_addr = '0;
   logic [15:0] snp_data = '0;
   logic        snp_shared_o, snp_supply_o;
   logic [15:0] snp_data_o;

   logic        other_sh = 0, gnt_hold = 0;
   logic [15:0] mem [256];
   int n_rd = 0, n_upd = 0, n_fl = 0;
   logic [1:0]  last_cmd = '0, prev_cmd = '0;
   logic [7:0]  last_addr = '0;
   logic [15:0] last_data = '0;
   int n_checks = 0, n_fail = 0;
   bit done = 0;

   assign bus_gnt      = bus_req && !gnt_hold;
   assign bus_shared_i = other_sh;
   assign bus_rdata_i  = mem[bus_addr_o];

   upd_coh_ctrl dut_i (.*);

   function automatic logic [15:0] memv(input logic [7:0] a);
      return 16'(a) * 16'd7 + 16'd3;
   endfunction

   initial for (int i = 0; i < 256; i++) mem[i] = memv(8'(i));

   // Bus monitor: each transaction occupies the cycle where req and gnt are high.
   always @(negedge clk) if (rst_n && bus_req && bus_gnt) begin
      prev_cmd  = last_cmd;
      last_cmd  = bus_cmd_o;
      last_addr = bus_addr_o;
      last_data = bus_data_o;
      case (bus_cmd_o)
         2'd1: n_rd++;
         2'd2: n_upd++;
         2'd3: begin n_fl++; mem[bus_addr_o] = bus_data_o; end
         default: ;
      endcase
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] d,
                         output logic [15:0] r);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      do @(negedge clk); while (!cpu_ack);
      r = cpu_rdata;
      cpu_req = 0;
   endtask

   task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                        output logic sh, output logic sup, output logic [15:0] sd);
      @(negedge clk);
      snp_valid = 1; snp_cmd = c; snp_addr = a; snp_data = d;
      #1;
      sh = snp_shared_o; sup = snp_supply_o; sd = snp_data_o;
      @(negedge clk);
      snp_valid = 0; snp_cmd = 2'd0;
   endtask

   logic [15:0] r, sd, rg;
   logic sh, sup;
   int b0, b1, b2;

   task automatic t_reset();
      chk(cpu_ack == 0, "R3 reset ack", cpu_ack, 0);
      chk(bus_req == 0, "R1 reset bus_req", bus_req, 0);
      chk(snp_shared_o == 0 && snp_supply_o == 0, "R11 reset snoop outs",
          {snp_shared_o, snp_supply_o}, 0);
   endtask

   task automatic t_excl_fill();
      other_sh = 0; b0 = n_rd;
      cpu_op(0, 8'h12, 0, r);
      chk(r == memv(8'h12), "R1 fill data", r, memv(8'h12));
      chk(n_rd == b0 + 1 && last_cmd == 2'd1, "R1 one bus read", n_rd - b0, 1);
      cpu_op(0, 8'h12, 0, r);
      chk(n_rd == b0 + 1, "R3 hit no bus read", n_rd - b0, 1);
      chk(r == memv(8'h12), "R3 hit data", r, memv(8'h12));
      b1 = n_upd;
      cpu_op(1, 8'h12, 16'hA001, r);
      chk(n_upd == b1, "R2 sole-clean write silent", n_upd - b1, 0);
      cpu_op(0, 8'h12, 0, r);
      chk(r == 16'hA001, "R5 written word read back", r, 16'hA001);
   endtask

   task automatic t_owner();
      snoop(2'd1, 8'h12, 0, sh, sup, sd);
      chk(sh && sup, "R6 dirty snoop shared+supply", {sh, sup}, 3);
      chk(sd == 16'hA001, "R6 supplied word", sd, 16'hA001);
      other_sh = 1; b0 = n_upd;
      cpu_op(1, 8'h12, 16'hB002, r);
      chk(n_upd == b0 + 1, "R4 update issued", n_upd - b0, 1);
      chk(last_addr == 8'h12 && last_data == 16'hB002, "R4 update payload", last_data, 16'hB002);
      chk(mem[8'h12] == memv(8'h12), "R4 memory untouched", mem[8'h12], memv(8'h12));
      snoop(2'd1, 8'h12, 0, sh, sup, sd);
      chk(sup && sd == 16'hB002, "R4 owner supplies", sd, 16'hB002);
   endtask

   task automatic t_snoop_upd();
      snoop(2'd2, 8'h12, 16'hC003, sh, sup, sd);
      chk(sh && !sup, "R8 update snoop shared", {sh, sup}, 2);
      snoop(2'd1, 8'h12, 0, sh, sup, sd);
      chk(sh && !sup, "R8 ownership released", {sh, sup}, 2);
      b0 = n_rd;
      cpu_op(0, 8'h12, 0, r);
      chk(r == 16'hC003 && n_rd == b0, "R8 broadcast word stored", r, 16'hC003);
   endtask

   task automatic t_upd_alone();
      other_sh = 0; b0 = n_upd;
      cpu_op(1, 8'h12, 16'hD004, r);
      chk(n_upd == b0 + 1, "R5 update with shared low", n_upd - b0, 1);
      cpu_op(1, 8'h12, 16'hD005, r);
      chk(n_upd == b0 + 1, "R5 sole-dirty write silent", n_upd - b0, 1);
   endtask

   task automatic t_replace();
      other_sh = 0; b0 = n_fl; b1 = n_rd;
      cpu_op(0, 8'h22, 0, r);
      chk(n_fl == b0 + 1 && n_rd == b1 + 1, "R9 flush then read", n_fl - b0, 1);
      chk(prev_cmd == 2'd3 && last_cmd == 2'd1, "R9 order", {prev_cmd, last_cmd}, 4'hD);
      chk(mem[8'h12] == 16'hD005, "R9 flushed word", mem[8'h12], 16'hD005);
      chk(r == memv(8'h22), "R9 new line data", r, memv(8'h22));
      b0 = n_fl; b1 = n_rd;
      cpu_op(0, 8'h32, 0, r);
      chk(n_fl == b0 && n_rd == b1 + 1, "R9 clean victim no flush", n_fl - b0, 0);
      chk(r == memv(8'h32), "R9 clean replace data", r, memv(8'h32));
   endtask

   task automatic t_excl_snoop();
      other_sh = 0;
      cpu_op(0, 8'h45, 0, r);
      snoop(2'd1, 8'h45, 0, sh, sup, sd);
      chk(sh && !sup, "R7 sole-clean snoop", {sh, sup}, 2);
      other_sh = 1; b0 = n_upd;
      cpu_op(1, 8'h45, 16'hE006, r);
      chk(n_upd == b0 + 1, "R7 now shared, write updates", n_upd - b0, 1);
   endtask

   task automatic t_miss_snoop();
      snoop(2'd1, 8'h99, 0, sh, sup, sd);
      chk(!sh && !sup, "R11 empty index", {sh, sup}, 0);
      snoop(2'd2, 8'h55, 16'h7777, sh, sup, sd);
      chk(!sh && !sup, "R11 tag mismatch", {sh, sup}, 0);
      b0 = n_rd;
      cpu_op(0, 8'h45, 0, r);
      chk(r == 16'hE006 && n_rd == b0, "R11 contents unchanged", r, 16'hE006);
   endtask

   task automatic t_counter();
      other_sh = 1;
      cpu_op(0, 8'h57, 0, r);
      chk(r == memv(8'h57), "R2 shared fill data", r, memv(8'h57));
      snoop(2'd2, 8'h57, 16'h1111, sh, sup, sd);
      snoop(2'd2, 8'h57, 16'h2222, sh, sup, sd);
      b0 = n_rd;
      cpu_op(0, 8'h57, 0, r);
      chk(r == 16'h2222 && n_rd == b0, "R10 kept below limit", r, 16'h2222);
      snoop(2'd2, 8'h57, 16'h3333, sh, sup, sd);
      snoop(2'd2, 8'h57, 16'h4444, sh, sup, sd);
      snoop(2'd2, 8'h57, 16'h5555, sh, sup, sd);
      b0 = n_rd; b1 = n_fl;
      cpu_op(0, 8'h57, 0, r);
      chk(n_rd == b0 + 1, "R10 dropped line misses", n_rd - b0, 1);
      chk(n_fl == b1, "R10 silent drop", n_fl - b1, 0);
      chk(r == memv(8'h57), "R10 refetched from memory", r, memv(8'h57));
   endtask

   task automatic t_grant_wait();
      other_sh = 0; gnt_hold = 1;
      fork cpu_op(0, 8'h6A, 0, rg); join_none
      repeat (6) @(negedge clk);
      chk(bus_req == 1 && bus_cmd_o == 2'd1, "R12 read pending", {bus_req, bus_cmd_o}, 5);
      chk(bus_addr_o == 8'h6A, "R12 address held", bus_addr_o, 8'h6A);
      chk(cpu_ack == 0, "R12 no ack before grant", cpu_ack, 0);
      gnt_hold = 0;
      wait fork;
      chk(rg == memv(8'h6A), "R12 data after grant", rg, memv(8'h6A));
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_excl_fill();
      t_owner();
      t_snoop_upd();
      t_upd_alone();
      t_replace();
      t_excl_snoop();
      t_miss_snoop();
      t_counter();
      t_grant_wait();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=complete");
         finish_run();
      end
   end
endmodule